// File: doc/BRIEF.md
# Ring Control and Interrupt Coalescer

This block is the per-ring register file and control logic of a descriptor ring engine. Software reaches it through 32-bit register writes and reads. It can switch the ring on and off and run a flush handshake. It can post doorbell counts and read back the completion write pointer. It also programs a message-signalled interrupt: the enable, a completion-count threshold, a timeout, a target address and a data word.

Each completion arrives as a one-cycle pulse on `cmpl_pulse`. While the ring is active and not flushing, every pulse advances a completion write pointer, kept in descriptor units, that wraps at the ring depth. The coalescer counts pending completions. It raises a one-cycle interrupt request when enough completions have gathered or when the oldest one has waited long enough. After a request it stays silent until software reads the completion write pointer. That same read is also what lets a flush finish. The programmed address and data sit on `irq_addr` and `irq_data` for the message sender downstream.

Top module: `ring_ctl_coalescer`

## Requirements
- R1: After reset, every mapped register reads zero and `irq_req` is low.
- R2: The control register sits at byte offset 0x034. Bit 4 activates the ring and bit 5 requests a flush. Only these two bits are stored, and all other bits read zero.
- R3: The completion write pointer at offset 0x01C advances by one on each `cmpl_pulse` while the ring is active and not flushing. Pulses are ignored while the ring is inactive.
- R4: The completion write pointer wraps from RING_DEPTH-1 to zero.
- R5: While the flush bit is set, the pointer is held at zero and completion pulses are ignored. Counting resumes from zero once the flush bit is cleared.
- R6: Bit 0 of the flush status register at offset 0x038 goes to 1 on the cycle after the completion write pointer is read while the flush bit is set. It does not go to 1 before that read. It returns to 0 after the flush bit is cleared.
- R7: Each write to the doorbell register at offset 0x074 adds the written value to an outstanding-descriptor count, which reads back at the same offset.
- R8: The interrupt control register at offset 0x048 stores a timeout in bits 31:16, an enable in bit 15 and a count threshold in bits 9:0, and all other bits read zero. The address words at 0x03C (low) and 0x040 (high) and the data word at 0x064 read back and drive `irq_addr` and `irq_data`.
- R9: With the interrupt enabled and armed, `irq_req` pulses once when the pending completion count reaches the threshold.
- R10: With the interrupt enabled and armed, `irq_req` pulses once when the number of clock ticks since the first pending completion reaches the timeout, even if the threshold has not been reached.
- R11: After `irq_req` pulses, no further request is raised until the completion write pointer is read. Completions that arrive in the meantime stay pending.
- R12: While the enable bit is clear, `irq_req` stays low. Pending completions are kept, so setting the enable later releases the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (the read side effects happen on this) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle |
| cmpl_pulse | input | 1 | One pulse per completed descriptor |
| ring_active | output | 1 | The ring is active and not flushing |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| irq_addr | output | 64 | Programmed interrupt message address |
| irq_data | output | 32 | Programmed interrupt message data |

## Verification
The coalescer is tried with a burst that ends one short of the threshold and then reaches it, which separates the count trigger from an early fire. A single completion under a huge threshold and a short timeout isolates the timer path. Pulses that follow a request, with no pointer read, and then a read, show that only the read re-arms. A disabled configuration that is later enabled shows that pending work is held, not dropped. Pointer patterns cover an inactive ring, a full wrap, and a flush in which the status is sampled both before and after the releasing read.

// File: rtl/ringctl_pkg.sv
package ringctl_pkg;

    localparam int REG_AW = 8;
    localparam int TMR_W  = 16;
    localparam int THR_W  = 10;

    // byte offsets that software decodes
    localparam logic [REG_AW-1:0] OFF_WPTR   = 8'h1C;
    localparam logic [REG_AW-1:0] OFF_CTL    = 8'h34;
    localparam logic [REG_AW-1:0] OFF_DONE   = 8'h38;
    localparam logic [REG_AW-1:0] OFF_ADR_LO = 8'h3C;
    localparam logic [REG_AW-1:0] OFF_ADR_HI = 8'h40;
    localparam logic [REG_AW-1:0] OFF_MSICFG = 8'h48;
    localparam logic [REG_AW-1:0] OFF_MDATA  = 8'h64;
    localparam logic [REG_AW-1:0] OFF_DBELL  = 8'h74;

    typedef struct packed {
        logic flush;
        logic active;
    } ring_ctl_t;

    typedef struct packed {
        logic [TMR_W-1:0] tmo;
        logic             en;
        logic [THR_W-1:0] thr;
    } msi_cfg_t;

    function automatic logic [31:0] msi_to_word(msi_cfg_t c);
        return {c.tmo, c.en, 5'b0, c.thr};
    endfunction

    function automatic msi_cfg_t word_to_msi(logic [31:0] w);
        msi_cfg_t c;
        c.tmo = w[31:16];
        c.en  = w[15];
        c.thr = w[THR_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/ringctl_regs.sv
module ringctl_regs
    import ringctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [31:0]       ptr_word,
    input  logic              flush_done,
    output ring_ctl_t         ctl,
    output msi_cfg_t          msi,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data,
    output logic [31:0]       rdata
);

    logic [31:0] outstanding;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl         <= '0;
            msi         <= '0;
            msg_addr    <= '0;
            msg_data    <= '0;
            outstanding <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_CTL:    begin
                    ctl.active <= wdata[4];
                    ctl.flush  <= wdata[5];
                end
                OFF_MSICFG: msi            <= word_to_msi(wdata);
                OFF_ADR_LO: msg_addr[31:0]  <= wdata;
                OFF_ADR_HI: msg_addr[63:32] <= wdata;
                OFF_MDATA:  msg_data       <= wdata;
                OFF_DBELL:  outstanding    <= outstanding + wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFF_CTL:    rdata = {26'b0, ctl.flush, ctl.active, 4'b0};
            OFF_DONE:   rdata = {31'b0, flush_done};
            OFF_WPTR:   rdata = ptr_word;
            OFF_MSICFG: rdata = msi_to_word(msi);
            OFF_ADR_LO: rdata = msg_addr[31:0];
            OFF_ADR_HI: rdata = msg_addr[63:32];
            OFF_MDATA:  rdata = msg_data;
            OFF_DBELL:  rdata = outstanding;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/ringctl_wptr.sv
module ringctl_wptr #(
    parameter int DEPTH = 1024,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          flush,
    input  logic          ptr_read,
    output logic [PW-1:0] ptr,
    output logic          done
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [PW-1:0] ONE  = PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            done <= 1'b0;
        end else begin
            if (flush)
                ptr <= '0;
            else if (step)
                ptr <= (ptr == LAST) ? '0 : ptr + ONE;
            // status latches once the pointer is read inside the flush
            done <= flush ? (done | ptr_read) : 1'b0;
        end
    end

endmodule

// File: rtl/ringctl_coalesce.sv
module ringctl_coalesce
    import ringctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  msi_cfg_t cfg,
    input  logic     evt,
    input  logic     rearm,
    input  logic     clear,
    output logic     fire
);

    localparam logic [THR_W-1:0] P_ONE = THR_W'(1);
    localparam logic [TMR_W-1:0] T_ONE = TMR_W'(1);

    logic [THR_W-1:0] pend;
    logic [TMR_W-1:0] tick;
    logic             armed;

    assign fire = cfg.en && armed && (pend != '0) &&
                  ((pend >= cfg.thr) || (tick >= cfg.tmo));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            tick  <= '0;
            armed <= 1'b1;
        end else begin
            // a pointer read re-arms, even in the cycle a request leaves
            if (rearm)
                armed <= 1'b1;
            else if (fire)
                armed <= 1'b0;

            if (clear) begin
                pend <= '0;
                tick <= '0;
            end else if (fire) begin
                pend <= evt ? P_ONE : '0;
                tick <= '0;
            end else begin
                if (evt && (pend != '1))
                    pend <= pend + P_ONE;
                if (pend == '0)
                    tick <= '0;
                else if (tick != '1)
                    tick <= tick + T_ONE;
            end
        end
    end

endmodule

// File: rtl/ring_ctl_coalescer.sv
module ring_ctl_coalescer
    import ringctl_pkg::*;
#(
    parameter int RING_DEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              cmpl_pulse,
    output logic              ring_active,
    output logic              irq_req,
    output logic [63:0]       irq_addr,
    output logic [31:0]       irq_data
);

    localparam int PW = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1;

    ring_ctl_t      ctl_q;
    msi_cfg_t       msi_q;
    logic [PW-1:0]  cmpl_ptr;
    logic [31:0]    ptr_word;
    logic           flush_done;
    logic           ptr_read;
    logic           step;
    logic           flush_on;
    logic           active_on;
    logic           msi_en_on;

    assign flush_on    = ctl_q.flush;
    assign active_on   = ctl_q.active;
    assign msi_en_on   = msi_q.en;
    assign ptr_read    = reg_rd_en && (reg_addr == OFF_WPTR);
    assign step        = cmpl_pulse && active_on && !flush_on;
    assign ring_active = active_on && !flush_on;
    assign ptr_word    = 32'(cmpl_ptr);

    ringctl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .ptr_word   (ptr_word),
        .flush_done (flush_done),
        .ctl        (ctl_q),
        .msi        (msi_q),
        .msg_addr   (irq_addr),
        .msg_data   (irq_data),
        .rdata      (reg_rdata)
    );

    ringctl_wptr #(.DEPTH(RING_DEPTH)) u_wptr (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .flush    (flush_on),
        .ptr_read (ptr_read),
        .ptr      (cmpl_ptr),
        .done     (flush_done)
    );

    ringctl_coalesce u_coal (
        .clk   (clk),
        .rst   (rst),
        .cfg   (msi_q),
        .evt   (step),
        .rearm (ptr_read),
        .clear (flush_on),
        .fire  (irq_req)
    );

endmodule

module ring_ctl_coalescer_chk #(
    parameter int DEPTH = 1024,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_rd_en,
    input logic [7:0]    reg_addr,
    input logic          irq_req,
    input logic [PW-1:0] ptr,
    input logic          flush_q,
    input logic          active_q,
    input logic          done,
    input logic          msi_en
);

    logic rdp;
    logic read_since_irq;

    assign rdp = reg_rd_en && (reg_addr == 8'h1C);

    always_ff @(posedge clk) begin
        if (rst)
            read_since_irq <= 1'b1;
        else if (rdp)
            read_since_irq <= 1'b1;
        else if (irq_req)
            read_since_irq <= 1'b0;
    end

    // R11: a request needs a pointer read since the previous one
    p_irq_gated_r11: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (read_since_irq || rdp));

    // R12: no request while disabled
    p_irq_enable_r12: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> msi_en);

    // R3 / R4: pointer moves by one step or returns to zero
    p_wptr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (ptr != $past(ptr)) |-> ((ptr == PW'($past(ptr) + 1'b1)) || (ptr == '0)));

    // R3: inactive ring keeps the pointer
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !flush_q) |=> $stable(ptr));

    // R5: flushing forces the pointer to zero
    p_flush_zero_r5: assert property (@(posedge clk) disable iff (rst)
        flush_q |=> (ptr == '0));

    // R6: flush status only during or right after a flush
    p_done_flush_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (flush_q || $past(flush_q)));

endmodule

bind ring_ctl_coalescer ring_ctl_coalescer_chk #(.DEPTH(RING_DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .irq_req   (irq_req),
    .ptr       (cmpl_ptr),
    .flush_q   (flush_on),
    .active_q  (active_on),
    .done      (flush_done),
    .msi_en    (msi_en_on)
);

// File: tb/tb_ring_ctl_coalescer.sv
module tb_ring_ctl_coalescer;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmpl_pulse = 1'b0;
    logic        ring_active;
    logic        irq_req;
    logic [63:0] irq_addr;
    logic [31:0] irq_data;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ring_ctl_coalescer #(.RING_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmpl_pulse(cmpl_pulse), .ring_active(ring_active), .irq_req(irq_req),
        .irq_addr(irq_addr), .irq_data(irq_data)
    );

    always @(negedge clk) if (!rst && irq_req) irq_cnt++;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); irq_cnt = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, d);
        chk(d == exp, req, 64'(d), 64'(exp));
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cmpl_pulse = 1'b1;
            @(posedge clk); #1 cmpl_pulse = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk(irq_req == 1'b0, "R1 irq_req", 64'(irq_req), 0);
        rd_chk(8'h34, 0, "R1 control");
        rd_chk(8'h38, 0, "R1 flush status");
        rd_chk(8'h1C, 0, "R1 write pointer");
        rd_chk(8'h74, 0, "R1 doorbell");
        rd_chk(8'h48, 0, "R1 interrupt control");
        rd_chk(8'h3C, 0, "R1 address low");
        rd_chk(8'h40, 0, "R1 address high");
        rd_chk(8'h64, 0, "R1 data");
    endtask

    task automatic t_ctrl();
        do_reset();
        wr(8'h34, 32'h10);
        rd_chk(8'h34, 32'h10, "R2 active bit");
        chk(ring_active == 1'b1, "R2 ring_active", 64'(ring_active), 1);
        wr(8'h34, 32'hFFFF_FFCF);
        rd_chk(8'h34, 32'h0, "R2 other bits dropped");
        wr(8'h34, 32'h30);
        rd_chk(8'h34, 32'h30, "R2 flush bit");
        chk(ring_active == 1'b0, "R2 flushing not active", 64'(ring_active), 0);
    endtask

    task automatic t_ptr();
        do_reset();
        pulse(3); idle(1);
        rd_chk(8'h1C, 0, "R3 inactive ignores pulses");
        wr(8'h34, 32'h10);
        pulse(5); idle(1);
        rd_chk(8'h1C, 5, "R3 five completions");
    endtask

    task automatic t_wrap();
        do_reset();
        wr(8'h34, 32'h10);
        pulse(DEPTH - 1); idle(1);
        rd_chk(8'h1C, 32'(DEPTH - 1), "R4 last slot");
        pulse(1); idle(1);
        rd_chk(8'h1C, 0, "R4 wrap to zero");
        pulse(2); idle(1);
        rd_chk(8'h1C, 2, "R4 after wrap");
    endtask

    task automatic t_flush();
        do_reset();
        wr(8'h34, 32'h10);
        pulse(7); idle(1);
        wr(8'h34, 32'h30);
        idle(2);
        rd_chk(8'h38, 0, "R6 not done before pointer read");
        rd_chk(8'h1C, 0, "R5 flush zeroes pointer");
        rd_chk(8'h38, 1, "R6 done after pointer read");
        pulse(3); idle(1);
        rd_chk(8'h1C, 0, "R5 pulses ignored in flush");
        wr(8'h34, 32'h10);
        idle(2);
        rd_chk(8'h38, 0, "R6 done clears");
        pulse(2); idle(1);
        rd_chk(8'h1C, 2, "R5 counting resumes from zero");
    endtask

    task automatic t_doorbell();
        do_reset();
        wr(8'h74, 32'd5);
        wr(8'h74, 32'h100);
        rd_chk(8'h74, 32'h105, "R7 doorbell sum");
    endtask

    task automatic t_msi_regs();
        do_reset();
        wr(8'h48, 32'hFFFF_FFFF);
        rd_chk(8'h48, 32'hFFFF_83FF, "R8 interrupt control fields");
        wr(8'h3C, 32'h1234_5678);
        wr(8'h40, 32'h9ABC_DEF0);
        wr(8'h64, 32'h0000_002A);
        rd_chk(8'h3C, 32'h1234_5678, "R8 address low");
        rd_chk(8'h40, 32'h9ABC_DEF0, "R8 address high");
        rd_chk(8'h64, 32'h2A, "R8 data");
        chk(irq_addr == 64'h9ABC_DEF0_1234_5678, "R8 irq_addr", irq_addr, 64'h9ABC_DEF0_1234_5678);
        chk(irq_data == 32'h2A, "R8 irq_data", 64'(irq_data), 64'h2A);
    endtask

    task automatic t_count();
        do_reset();
        wr(8'h34, 32'h10);
        wr(8'h48, 32'hFFFF_8004);
        pulse(3); idle(2);
        chk(irq_cnt == 0, "R9 below threshold", 64'(irq_cnt), 0);
        pulse(1); idle(2);
        chk(irq_cnt == 1, "R9 threshold reached", 64'(irq_cnt), 1);
    endtask

    task automatic t_timer();
        do_reset();
        wr(8'h34, 32'h10);
        wr(8'h48, 32'h0006_83FF);
        pulse(1); idle(3);
        chk(irq_cnt == 0, "R10 before timeout", 64'(irq_cnt), 0);
        idle(6);
        chk(irq_cnt == 1, "R10 timeout fired", 64'(irq_cnt), 1);
    endtask

    task automatic t_gate();
        do_reset();
        wr(8'h34, 32'h10);
        wr(8'h48, 32'hFFFF_8001);
        pulse(1); idle(2);
        chk(irq_cnt == 1, "R11 first request", 64'(irq_cnt), 1);
        pulse(4); idle(3);
        chk(irq_cnt == 1, "R11 blocked until read", 64'(irq_cnt), 1);
        rd_chk(8'h1C, 5, "R11 pointer read");
        idle(2);
        chk(irq_cnt == 2, "R11 re-armed by read", 64'(irq_cnt), 2);
    endtask

    task automatic t_disable();
        do_reset();
        wr(8'h34, 32'h10);
        wr(8'h48, 32'h0000_0001);
        pulse(3); idle(5);
        chk(irq_cnt == 0, "R12 disabled no request", 64'(irq_cnt), 0);
        wr(8'h48, 32'h0000_8001);
        idle(2);
        chk(irq_cnt == 1, "R12 pending released on enable", 64'(irq_cnt), 1);
    endtask

    initial begin
        t_reset();
        t_ctrl();
        t_ptr();
        t_wrap();
        t_flush();
        t_doorbell();
        t_msi_regs();
        t_count();
        t_timer();
        t_gate();
        t_disable();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule